// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel that sits beside a free-running 16-bit up-counter. Software writes and reads one channel register through a simple strobe interface. The same register serves two purposes, chosen by a 2-bit mode input. In the two compare modes, a written value passes to a shadow buffer. A match between the counter and that buffer raises a one-clock interrupt pulse and may invert an output pin. In the two capture modes, a qualified edge on an external trigger input copies the counter into the channel register. In pulse-width mode the capture also asks the counter to restart from zero.

The counter, its prescaler and its period logic live outside the block. The channel takes the count and the period (reload) value as inputs and returns a counter-clear request. All outputs are registered. The trigger input is treated as asynchronous and passes through a two-stage synchronizer before edge qualification.

Top module: `tmr_cc_channel`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge: read data, interrupt, clear request, pin level and pending flag.
- R2: A write strobe in a compare mode (mode 00 or 01) stores the data into the channel register whatever the enable bit is. In a capture mode (10 or 11) the write is ignored. A read strobe sampled at an edge presents the channel register on `rd_data_o` after that edge, and the value is held until the next read.
- R3: In immediate mode (00) a write also loads the shadow buffer at the same edge. At each edge where the counter is enabled and `count_i` equals the buffer, `match_irq_o` is 1 for the following cycle. Otherwise it is 0.
- R4: In batched mode (01) a write leaves the buffer unchanged and sets `wr_pend_o`. At an edge where the counter is enabled and `count_i` equals `period_i`, the buffer takes the channel register and `wr_pend_o` clears, unless a write arrives at that same edge, in which case the flag stays set. Mode 00 keeps `wr_pend_o` at 0.
- R5: On each compare match, `cmp_out_o` inverts if `out_en_i` was 1 at that edge. With `out_en_i` at 0 it holds its level.
- R6: `edge_sel_i` selects the capture edge: 00 none, 01 rising, 10 falling, 11 both. An input change made between two clock edges is captured at the third rising clock edge after it, storing the `count_i` present at that edge.
- R7: In free-running capture mode (10) a capture updates the channel register and never raises `clr_req_o`.
- R8: In pulse-width mode (11) a capture also drives `clr_req_o` high for exactly the following cycle. With a counter that clears on that request, two edges D cycles apart capture D-2 on the second edge.
- R9: At every edge with the counter disabled, a capture-mode channel register becomes 0, while a compare-mode channel register keeps its value (apart from writes).
- R10: A read sampled at the same edge as a capture returns the value before the capture. A read one cycle later returns the captured value.
- R11: While the counter is disabled, no compare match, no capture and no clear request occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Counter enable bit |
| mode_i | input | 2 | 00 immediate compare, 01 batched compare, 10 free capture, 11 pulse-width capture |
| edge_sel_i | input | 2 | Capture edge select: 00 none, 01 rise, 10 fall, 11 both |
| out_en_i | input | 1 | Compare pin toggle enable |
| wr_en_i | input | 1 | Channel register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Channel register read strobe |
| rd_data_o | output | 16 | Registered read data |
| count_i | input | 16 | Current counter value |
| period_i | input | 16 | Counter reload value, the batched transfer point |
| cap_in_i | input | 1 | Asynchronous capture trigger |
| match_irq_o | output | 1 | Compare-match interrupt pulse |
| clr_req_o | output | 1 | Counter clear request |
| cmp_out_o | output | 1 | Compare output pin |
| wr_pend_o | output | 1 | Batched write waiting for transfer |

## Verification
Compare behaviour is swept over every buffer value from 0 to 15 against a counter that wraps at 11. Buffer values above the period must never match, which separates a real equality test from one that fires on a wrap. Writes land both before and during a counting run, so the immediate and batched paths are told apart by when the match pattern moves. Capture behaviour is swept over all four edge encodings and several pulse gaps in both capture modes, with reads on every cycle. This exposes edge qualification errors, an off-by-one in synchronizer depth and a stale-versus-fresh read at the capture edge. Directed runs then pin down the pulse-width arithmetic (D-2), clear-on-disable against hold-on-disable, and the absence of matches while the counter is stopped on an equal value.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef enum logic [1:0] {
    CC_CMP_IMM   = 2'b00,
    CC_CMP_BATCH = 2'b01,
    CC_CAP_FREE  = 2'b10,
    CC_CAP_PULSE = 2'b11
  } cc_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cc_edge_e;

  function automatic logic is_capture(input cc_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/cc_edge_detect.sv
module cc_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sig_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], sig_i};
      end
    end
  endgenerate

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  always_comb begin
    edge_o = (sel_i[0] & synced & ~prev_q) |
             (sel_i[1] & ~synced & prev_q);
  end
endmodule

// File: rtl/cc_chan_reg.sv
module cc_chan_reg
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  cc_mode_e         mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] chan_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             clr_o
);
  logic [CNT_W-1:0] chan_q;
  logic             cap_mode;
  logic             take_cap;

  always_comb begin
    cap_mode = is_capture(mode_i);
    take_cap = cnt_en_i & cap_mode & edge_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q    <= '0;
      rd_data_o <= '0;
      clr_o     <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= chan_q;
      clr_o <= take_cap & (mode_i == CC_CAP_PULSE);
      if (cap_mode) begin
        if (!cnt_en_i)    chan_q <= '0;
        else if (take_cap) chan_q <= count_i;
      end else if (wr_en_i) begin
        chan_q <= wr_data_i;
      end
    end
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  cc_mode_e         mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] chan_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             out_en_i,
  output logic             irq_o,
  output logic             pin_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] shadow_q;
  logic             hit;
  logic             reload;

  always_comb begin
    hit    = cnt_en_i & ~is_capture(mode_i) & (count_i == shadow_q);
    reload = cnt_en_i & (mode_i == CC_CMP_BATCH) & (count_i == period_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      pend_o   <= 1'b0;
      irq_o    <= 1'b0;
      pin_o    <= 1'b0;
    end else begin
      irq_o <= hit;
      if (hit && out_en_i) pin_o <= ~pin_o;
      case (mode_i)
        CC_CMP_IMM: begin
          if (wr_en_i) shadow_q <= wr_data_i;
          pend_o <= 1'b0;
        end
        CC_CMP_BATCH: begin
          if (reload) shadow_q <= chan_i;
          if (wr_en_i)     pend_o <= 1'b1;
          else if (reload) pend_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             out_en_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cap_in_i,
  output logic             match_irq_o,
  output logic             clr_req_o,
  output logic             cmp_out_o,
  output logic             wr_pend_o
);
  cc_mode_e         mode;
  logic             cap_edge;
  logic [CNT_W-1:0] chan_q;

  assign mode = cc_mode_e'(mode_i);

  cc_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (cap_in_i),
    .sel_i  (edge_sel_i),
    .edge_o (cap_edge)
  );

  cc_chan_reg #(.CNT_W(CNT_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .cnt_en_i  (cnt_en_i),
    .mode_i    (mode),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .edge_i    (cap_edge),
    .count_i   (count_i),
    .chan_o    (chan_q),
    .rd_data_o (rd_data_o),
    .clr_o     (clr_req_o)
  );

  cc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .cnt_en_i  (cnt_en_i),
    .mode_i    (mode),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .chan_i    (chan_q),
    .count_i   (count_i),
    .period_i  (period_i),
    .out_en_i  (out_en_i),
    .irq_o     (match_irq_o),
    .pin_o     (cmp_out_o),
    .pend_o    (wr_pend_o)
  );
endmodule

// File: rtl/tmr_cc_checker.sv
module tmr_cc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en_i,
  input logic [1:0]       mode_i,
  input logic             out_en_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] chan_q,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             match_irq_o,
  input logic             clr_req_o,
  input logic             cmp_out_o,
  input logic             wr_pend_o
);
  p_irq_cmp_only_r3: assert property (@(posedge clk) disable iff (rst)
    match_irq_o |-> $past(!mode_i[1]));

  p_pend_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_pend_o && cnt_en_i && mode_i == 2'b01 && count_i == period_i && !wr_en_i)
      |=> !wr_pend_o);

  p_pin_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !out_en_i |=> $stable(cmp_out_o));

  p_clr_pulse_only_r8: assert property (@(posedge clk) disable iff (rst)
    clr_req_o |-> $past(mode_i == 2'b11 && cnt_en_i));

  p_cap_zero_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_i && mode_i[1]) |=> (chan_q == '0));

  p_cmp_keep_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_i && !mode_i[1] && !wr_en_i) |=> $stable(chan_q));

  p_read_old_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> (rd_data_o == $past(chan_q)));

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (rst)
    !cnt_en_i |=> (!match_irq_o && !clr_req_o));
endmodule

bind tmr_cc_channel tmr_cc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_en_i    (cnt_en_i),
  .mode_i      (mode_i),
  .out_en_i    (out_en_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .count_i     (count_i),
  .period_i    (period_i),
  .chan_q      (chan_q),
  .rd_data_o   (rd_data_o),
  .match_irq_o (match_irq_o),
  .clr_req_o   (clr_req_o),
  .cmp_out_o   (cmp_out_o),
  .wr_pend_o   (wr_pend_o)
);

// File: tb/sim_tmr_cc_channel.sv
`timescale 1ns/1ps
module sim_tmr_cc_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  esel = 2'b00;
  logic        oe = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] cnt = '0;
  logic [15:0] period = 16'd11;
  logic        cap_in = 1'b0;
  logic        irq, clr, pin, pend;

  int total = 0;
  int bad   = 0;
  logic chk_on = 1'b0;
  logic done   = 1'b0;

  always #10 clk = ~clk;

  tmr_cc_channel u0 (
    .clk(clk), .rst(rst), .cnt_en_i(cnt_en), .mode_i(mode), .edge_sel_i(esel),
    .out_en_i(oe), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .count_i(cnt), .period_i(period), .cap_in_i(cap_in),
    .match_irq_o(irq), .clr_req_o(clr), .cmp_out_o(pin), .wr_pend_o(pend)
  );

  // external counter: wraps at period, restarts on clear request
  always @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (cnt_en) cnt <= (cnt == period) ? 16'd0 : cnt + 16'd1;
  end

  // reference model built from the requirements
  logic [15:0] m_chan, m_buf, m_rd;
  logic        m_pend, m_irq, m_out, m_clr, m_s0, m_s1, m_prev;
  always @(posedge clk) begin : ref_model
    logic hit, ev, cap;
    if (rst) begin
      m_chan = '0; m_buf = '0; m_rd = '0; m_pend = 0; m_irq = 0; m_out = 0;
      m_clr = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
    end else begin
      ev  = (esel[0] && m_s1 && !m_prev) || (esel[1] && !m_s1 && m_prev);
      cap = cnt_en && mode[1] && ev;
      hit = cnt_en && !mode[1] && (cnt == m_buf);
      if (rd_en) m_rd = m_chan;
      m_irq = hit;
      if (hit && oe) m_out = !m_out;
      m_clr = cap && (mode == 2'b11);
      if (mode == 2'b00) begin
        if (wr_en) m_buf = wr_data;
        m_pend = 0;
      end else if (mode == 2'b01) begin
        if (cnt_en && cnt == period) begin m_buf = m_chan; m_pend = 0; end
        if (wr_en) m_pend = 1;
      end
      if (mode[1]) begin
        if (!cnt_en)  m_chan = '0;
        else if (cap) m_chan = cnt;
      end else if (wr_en) m_chan = wr_data;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = cap_in;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R3 match pulse", {15'd0, irq}, {15'd0, m_irq});
      chk("R5 pin level", {15'd0, pin}, {15'd0, m_out});
      chk("R4 pending flag", {15'd0, pend}, {15'd0, m_pend});
      chk("R8 clear request", {15'd0, clr}, {15'd0, m_clr});
      chk("R2/R10 read data", rd_data, m_rd);
    end
  end

  task automatic do_wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      report();
    end
  end

  initial begin
    logic [15:0] v, c0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 clr", {15'd0, clr}, 16'h0);
    chk("R1 pin", {15'd0, pin}, 16'h0);
    chk("R1 pend", {15'd0, pend}, 16'h0);
    rst = 1'b0;
    chk_on = 1'b1;

    // compare sweep: both write styles, buffer values 0..15, period 11
    for (int m = 0; m < 2; m++) begin
      mode = m[1:0];
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        oe = k[0]; rd_en = k[2]; cnt_en = k[1];
        wr_en = 1'b1; wr_data = k[15:0];
        @(negedge clk); wr_en = 1'b0; cnt_en = 1'b1;
        repeat (6) @(negedge clk);
        wr_en = 1'b1; wr_data = 16'((k + 3) % 16);
        @(negedge clk); wr_en = 1'b0;
        repeat (14) @(negedge clk);
        cnt_en = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    rd_en = 1'b0; oe = 1'b0;

    // capture sweep: both capture modes, every edge select, several gaps
    period = 16'hFFFF;
    rd_en = 1'b1;
    for (int m = 2; m < 4; m++) begin
      mode = m[1:0];
      for (int e = 0; e < 4; e++) begin
        esel = e[1:0];
        for (int g = 3; g < 7; g++) begin
          @(negedge clk); cnt_en = 1'b1; cap_in = ~cap_in;
          repeat (g) @(negedge clk);
          cap_in = ~cap_in;
          repeat (g + 2) @(negedge clk);
          cnt_en = 1'b0;
          @(negedge clk);
        end
      end
    end
    rd_en = 1'b0;
    cap_in = 1'b0;
    repeat (4) @(negedge clk);

    // R6/R7: rising capture latency in free-running mode
    mode = 2'b10; esel = 2'b01; cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    c0 = cnt; cap_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 no clear in free mode", {15'd0, clr}, 16'h0);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R6 captured count", rd_data, c0 + 16'd2);
    do_wr(16'hBEEF);
    do_rd(v);
    chk("R2 write ignored in capture", v, c0 + 16'd2);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    do_rd(v);
    chk("R6 falling edge ignored by rise select", v, c0 + 16'd2);
    @(negedge clk); cnt_en = 1'b0;
    do_rd(v);
    chk("R9 capture reg cleared on disable", v, 16'h0);

    // R8/R10: pulse width with D = 6
    mode = 2'b11; esel = 2'b11; cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    c0 = cnt; cap_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 clear pulse", {15'd0, clr}, 16'h1);
    repeat (3) @(negedge clk);
    cap_in = 1'b0;
    repeat (2) @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    chk("R10 read at capture edge is old", rd_data, c0 + 16'd2);
    @(negedge clk); rd_en = 1'b0;
    chk("R8 width D-2", rd_data, 16'd4);

    // R11 and R9: stopped counter sitting on the buffer value
    mode = 2'b00; cnt_en = 1'b0; esel = 2'b00;
    @(negedge clk);
    v = cnt;
    do_wr(v);
    repeat (4) @(negedge clk);
    chk("R11 no match while stopped", {15'd0, irq}, 16'h0);
    do_rd(c0);
    chk("R9 compare reg kept on disable", c0, v);

    // R2: write while counting in immediate mode
    cnt_en = 1'b1; period = 16'd11;
    do_wr(16'h1357);
    do_rd(v);
    chk("R2 write while enabled", v, 16'h1357);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    chk_on = 1'b0;
    report();
  end
endmodule